// File: doc/BRIEF.md
# Configurable Registered Sum-of-Products Array

This block is a small programmable logic array. It takes `N_IN` input signals and forms `N_TERM` product terms in a programmable AND plane. A programmable OR plane then sums those terms into `N_OUT` outputs. Every input is buffered in both its true and its complemented form. Each product term picks, for every input, the true form, the complemented form, or neither. Any product term may feed any number of outputs.

After the OR plane, each output passes through a polarity stage that can invert it. A per-output select then picks either the combinational value or a copy held in a clocked flip-flop.

The whole configuration is loaded serially through a one-bit shift port. While loading is in progress, the outputs are held at zero. The block suits glue logic and small decoders whose function must be chosen after the chip is built.

Top module: `registered_pla`

## Requirements
- R1: Each (term, input) literal is a 2-bit code: 00 leaves the input out of the term, 01 uses the true input, and 10 uses the complemented input. A term is the AND of the literals it uses.
- R2: The literal code 11 forces its product term to 0, whatever the inputs.
- R3: A product term whose literals are all 00 evaluates to 1.
- R4: An OR-plane bit of 1 connects a term to an output, and one term may drive several outputs. An output with no connected term is 0 before the polarity stage.
- R5: A polarity bit of 1 inverts its output. A polarity bit of 0 passes the output unchanged.
- R6: An output whose select bit is 0 is combinational: it follows `pla_in` with no clock edge.
- R7: An output whose select bit is 1 changes only at a rising clock edge. It shows the value the array computed from the inputs present before that edge.
- R8: A synchronous active-high `rst` clears the output flip-flops and the whole configuration. After reset, every output reads 0 for all inputs.
- R9: On each rising edge with `cfg_en` high, `cfg_bit` is shifted in. After `CFG_LEN` bits, the first bit sent sits at index 0.
- R10: The configuration index layout is as follows. Literal (t,i) sits at bits 2*(t*N_IN+i) and 2*(t*N_IN+i)+1. OR bit (t,o) sits at AND_W + t*N_OUT + o. The polarity bits of the outputs follow, then their select bits.
- R11: While `cfg_en` is high, every output reads 0. While `cfg_en` is low, the configuration does not change, whatever `cfg_bit` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration shift and the output flip-flops |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Shift enable for configuration loading |
| cfg_bit | input | 1 | Serial configuration data |
| pla_in | input | N_IN | Array inputs |
| pla_out | output | N_OUT | Array outputs after polarity and output select |

## Verification
On every cycle, the assertions check several properties:
- a term with a forcing literal stays 0, and an all-ignore term stays 1;
- an unconnected output equals its polarity bit;
- outputs are zero during loading, and the configuration is stable when loading is off;
- a registered output shows the array value from the previous cycle.

Other behaviours can only be shown by the bench's scenarios. These are:
- the serial bit order and the index layout;
- the shared-term self-test functions over all eight input patterns;
- the polarity and mixed-mode output selection;
- the clearing effect of reset.

// File: rtl/pla_pkg.sv
package pla_pkg;
    typedef enum logic [1:0] {
        LIT_SKIP = 2'b00,
        LIT_POS  = 2'b01,
        LIT_NEG  = 2'b10,
        LIT_KILL = 2'b11
    } lit_e;
endpackage

// File: rtl/pla_cfg_shift.sv
module pla_cfg_shift #(
    parameter int LEN = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_en,
    input  logic           shift_bit,
    output logic [LEN-1:0] bits
);
    typedef struct packed {
        logic [LEN-1:0] bits;
    } cfg_s;

    cfg_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.bits = {shift_bit, st_q.bits[LEN-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign bits = st_q.bits;

    // R11: configuration holds while shifting is off
    a_r11_cfg_stable: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(bits));
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
    import pla_pkg::*;
#(
    parameter int N_IN   = 3,
    parameter int N_TERM = 5,
    localparam int AND_W = 2 * N_IN * N_TERM
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_IN-1:0]   sig_in,
    input  logic [AND_W-1:0]  lit_cfg,
    output logic [N_TERM-1:0] terms
);
    logic [N_IN-1:0] buf_true, buf_comp;

    assign buf_true = sig_in;
    assign buf_comp = ~sig_in;

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        always_comb begin
            terms[t] = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                case (lit_e'(lit_cfg[2*(t*N_IN+i) +: 2]))
                    LIT_POS:  terms[t] = terms[t] & buf_true[i];
                    LIT_NEG:  terms[t] = terms[t] & buf_comp[i];
                    LIT_KILL: terms[t] = 1'b0;
                    default:  terms[t] = terms[t];
                endcase
            end
        end

        // R3: a term that uses no literal is 1
        a_r3_empty_term_one: assert property (@(posedge clk) disable iff (rst)
            (lit_cfg[2*t*N_IN +: 2*N_IN] == '0) |-> terms[t]);

        for (genvar i = 0; i < N_IN; i++) begin : g_lit
            // R2: a forcing literal kills its term
            a_r2_kill_term: assert property (@(posedge clk) disable iff (rst)
                (lit_cfg[2*(t*N_IN+i) +: 2] == 2'b11) |-> !terms[t]);
        end
    end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_TERM = 5,
    parameter int N_OUT  = 4,
    localparam int OR_W  = N_TERM * N_OUT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TERM-1:0] terms,
    input  logic [OR_W-1:0]   conn_cfg,
    input  logic [N_OUT-1:0]  pol,
    output logic [N_OUT-1:0]  sums
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [N_TERM-1:0] col;
        logic              raw;

        always_comb begin
            for (int t = 0; t < N_TERM; t++) begin
                col[t] = conn_cfg[t*N_OUT + o];
            end
            raw = |(terms & col);
        end

        assign sums[o] = raw ^ pol[o];

        // R4: an output with nothing connected equals its polarity bit
        a_r4_unconnected: assert property (@(posedge clk) disable iff (rst)
            (col == '0) |-> (sums[o] == pol[o]));
    end
endmodule

// File: rtl/registered_pla.sv
module registered_pla #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 5,
    parameter int N_OUT  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_bit,
    input  logic [N_IN-1:0]  pla_in,
    output logic [N_OUT-1:0] pla_out
);
    localparam int AND_W    = 2 * N_IN * N_TERM;
    localparam int OR_W     = N_TERM * N_OUT;
    localparam int POL_BASE = AND_W + OR_W;
    localparam int SEL_BASE = POL_BASE + N_OUT;
    localparam int CFG_LEN  = SEL_BASE + N_OUT;

    typedef struct packed {
        logic [N_OUT-1:0] out_reg;
    } out_s;

    logic [CFG_LEN-1:0] cfg_vec;
    logic [N_TERM-1:0]  term_vec;
    logic [N_OUT-1:0]   comb_val;
    logic [N_OUT-1:0]   pol, sel;
    out_s               st_d, st_q;

    pla_cfg_shift #(.LEN(CFG_LEN)) u_cfg (
        .clk(clk), .rst(rst), .shift_en(cfg_en), .shift_bit(cfg_bit), .bits(cfg_vec)
    );

    pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .clk(clk), .rst(rst), .sig_in(pla_in), .lit_cfg(cfg_vec[AND_W-1:0]),
        .terms(term_vec)
    );

    assign pol = cfg_vec[POL_BASE +: N_OUT];
    assign sel = cfg_vec[SEL_BASE +: N_OUT];

    pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
        .clk(clk), .rst(rst), .terms(term_vec), .conn_cfg(cfg_vec[AND_W +: OR_W]),
        .pol(pol), .sums(comb_val)
    );

    always_comb begin
        st_d.out_reg = cfg_en ? '0 : comb_val;
        for (int o = 0; o < N_OUT; o++) begin
            if (cfg_en)      pla_out[o] = 1'b0;
            else if (sel[o]) pla_out[o] = st_q.out_reg[o];
            else             pla_out[o] = comb_val[o];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R11: outputs are quiet during loading
    a_r11_load_quiet: assert property (@(posedge clk) disable iff (rst)
        cfg_en |-> (pla_out == '0));

    for (genvar o = 0; o < N_OUT; o++) begin : g_chk
        // R7: a registered output shows last cycle's array value
        a_r7_reg_delay: assert property (@(posedge clk) disable iff (rst)
            (!cfg_en && sel[o] && $past(!cfg_en) && !$past(rst))
            |-> (pla_out[o] == $past(comb_val[o])));
    end
endmodule

// File: tb/registered_pla_tb.sv
module registered_pla_tb;
    localparam int N_IN = 3, N_TERM = 5, N_OUT = 4;
    localparam int AND_W = 2 * N_IN * N_TERM;
    localparam int OR_W = N_TERM * N_OUT;
    localparam int POL_BASE = AND_W + OR_W;
    localparam int SEL_BASE = POL_BASE + N_OUT;
    localparam int CFG_LEN = SEL_BASE + N_OUT;

    logic clk = 1'b0, rst = 1'b1, cfg_en = 1'b0, cfg_bit = 1'b0;
    logic [N_IN-1:0] pla_in = '0;
    logic [N_OUT-1:0] pla_out;
    logic [CFG_LEN-1:0] cfg;
    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    registered_pla #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
        .pla_in(pla_in), .pla_out(pla_out)
    );

    task automatic check(input string req, input logic [N_OUT-1:0] act, input logic [N_OUT-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic set_lit(input int t, input int i, input logic [1:0] code);
        cfg[2*(t*N_IN+i) +: 2] = code;
    endtask

    task automatic set_conn(input int t, input int o);
        cfg[AND_W + t*N_OUT + o] = 1'b1;
    endtask

    function automatic logic [N_OUT-1:0] ref_eval(input logic [CFG_LEN-1:0] c, input logic [N_IN-1:0] x);
        logic [N_OUT-1:0] r = '0;
        for (int t = 0; t < N_TERM; t++) begin
            logic tv = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                case (c[2*(t*N_IN+i) +: 2])
                    2'b01: tv = tv & x[i];
                    2'b10: tv = tv & ~x[i];
                    2'b11: tv = 1'b0;
                    default: ;
                endcase
            end
            for (int o = 0; o < N_OUT; o++) r[o] = r[o] | (tv & c[AND_W + t*N_OUT + o]);
        end
        return r ^ c[POL_BASE +: N_OUT];
    endfunction

    task automatic load_cfg(input bit mid_check);
        for (int k = 0; k < CFG_LEN; k++) begin
            @(negedge clk);
            cfg_en = 1'b1;
            cfg_bit = cfg[k];
            if (mid_check && k == CFG_LEN / 2) begin
                #1 check("R11 outputs zero while loading", pla_out, '0);
            end
        end
        @(negedge clk);
        cfg_en = 1'b0;
        cfg_bit = 1'b0;
    endtask

    task automatic build_selftest(input logic [N_OUT-1:0] pol, input logic [N_OUT-1:0] sel);
        cfg = '0;
        set_lit(0, 0, 2'b01); set_lit(0, 1, 2'b01);   // AB
        set_lit(1, 1, 2'b10); set_lit(1, 2, 2'b01);   // B'C
        set_lit(2, 0, 2'b01); set_lit(2, 2, 2'b10);   // AC'
        set_lit(3, 1, 2'b10); set_lit(3, 2, 2'b10);   // B'C'
        set_lit(4, 0, 2'b01);                         // A
        set_conn(4, 0); set_conn(3, 0);
        set_conn(2, 1); set_conn(0, 1);
        set_conn(3, 2); set_conn(0, 2);
        set_conn(1, 3); set_conn(4, 3);
        cfg[POL_BASE +: N_OUT] = pol;
        cfg[SEL_BASE +: N_OUT] = sel;
    endtask

    function automatic logic [N_OUT-1:0] hand_eval(input logic [2:0] x);
        logic a = x[0], b = x[1], c = x[2];
        return {(~b & c) | a, (~b & ~c) | (a & b), (a & ~c) | (a & b), a | (~b & ~c)};
    endfunction

    task automatic t_reset;
        check("R8 reset state", pla_out, '0);
    endtask

    task automatic t_selftest_comb;
        build_selftest('0, '0);
        load_cfg(1'b1);
        for (int v = 0; v < 8; v++) begin
            pla_in = v[2:0];
            #1;
            check("R1 R4 R6 R9 R10 shared-term functions", pla_out, hand_eval(v[2:0]));
            #1;
        end
    endtask

    task automatic t_polarity;
        build_selftest(4'b0101, '0);
        load_cfg(1'b0);
        for (int v = 0; v < 8; v++) begin
            pla_in = v[2:0];
            #1;
            check("R5 polarity", pla_out, hand_eval(v[2:0]) ^ 4'b0101);
            #1;
        end
    endtask

    task automatic t_registered(input logic [N_OUT-1:0] sel);
        logic [N_OUT-1:0] prev;
        logic [N_OUT-1:0] now_v;
        build_selftest(4'b0010, sel);
        load_cfg(1'b0);
        pla_in = '0;
        @(posedge clk);
        @(negedge clk);
        prev = ref_eval(cfg, '0);
        for (int v = 1; v < 8; v++) begin
            pla_in = v[2:0];
            now_v = ref_eval(cfg, v[2:0]);
            #1 check("R7 R6 before edge", pla_out, (prev & sel) | (now_v & ~sel));
            @(posedge clk);
            #1 check("R7 after edge", pla_out, now_v);
            prev = now_v;
            @(negedge clk);
        end
    endtask

    task automatic t_corner_terms;
        cfg = '0;
        set_lit(0, 0, 2'b11);
        set_conn(0, 0);
        set_conn(1, 1);
        cfg[POL_BASE + 3] = 1'b1;
        load_cfg(1'b1);
        for (int v = 0; v < 8; v++) begin
            pla_in = v[2:0];
            #1;
            check("R2 R3 R4 R5 kill/empty/unconnected", pla_out, 4'b1010);
            #1;
        end
    endtask

    task automatic t_cfg_hold;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            cfg_bit = k[0];
        end
        for (int v = 0; v < 8; v++) begin
            pla_in = v[2:0];
            #1;
            check("R11 config holds with cfg_en low", pla_out, 4'b1010);
            #1;
        end
    endtask

    task automatic t_reset_clear;
        build_selftest('1, '1);
        load_cfg(1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int v = 0; v < 8; v++) begin
            pla_in = v[2:0];
            #1;
            check("R8 reset clears configuration", pla_out, '0);
            #1;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_selftest_comb();
        t_polarity();
        t_registered(4'b1111);
        t_registered(4'b0011);
        t_corner_terms();
        t_cfg_hold();
        t_reset_clear();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule